// File: doc/BRIEF.md
# Memory address decoder with nonexistent-memory abort

This block sits between a 22-bit, byte-addressed processor bus and a bank of 16-bit static RAM. Each bus request is accepted on a clock edge. The block captures the word part of the address and, through a separate register with true and inverted outputs, the four upper address bits. From the captured address it derives three things: the RAM chip enable, a nonexistent-memory flag, and an active-low abort that the processor can use to trap a cycle that landed in unpopulated space. A small behavioural RAM model inside the block stores the words, so aliasing and discarded writes can be seen at the ports.

A mode input, sampled only while reset is held, selects the installed memory size. In the small mode the size is 128K words, and the upper bits that count are A18..A21. In the large mode the size is 512K words, and A18..A19 become word-address bits while only A20..A21 mark nonexistent space. A build parameter can remove the upper-bit register. In that variant the RAM sees only A1..A17 and repeats every 128K words, and nothing is ever flagged nonexistent. The top 4K words (8 KB) of the space are the I/O page, and the memory side never responds there.

The request side is valid/ready. A master holds `req_valid` and its fields steady until it sees `req_ready` high at a clock edge. `req_ready` drops for the one data-phase cycle after each acceptance, so requests are accepted at most every other cycle. The response has no ready signal. `rsp_valid` is high for exactly one cycle and must be taken in that cycle.

Top module: `memdec_top`

## Requirements
- R1: A request is accepted at an edge where `req_valid` and `req_ready` are both 1. In the following cycle `rsp_valid` is 1 and `req_ready` is 0. In the cycle after that, `rsp_valid` is 0 and `req_ready` is 1 again.
- R2: After synchronous reset the decoded address is 0. That means `ram_ce_o`=1, `nxm_o`=0, abort released, `rsp_valid`=0 and `req_ready`=1. Reset also empties the RAM model, so any word not yet written reads 16'h0000.
- R3: With the upper-bit register disabled (`UPPER_EN`=0), the RAM word index is A1..A17, and A18..A21 and the mode input have no effect. `ram_ce_o` is 1 outside the I/O page and `nxm_o` is always 0. A write at any 128K-word alias therefore reads back at every other alias.
- R4: In small mode with the upper register present, `ram_ce_o` equals NOT A18 (outside the I/O page). `nxm_o` is 1 when any of A18..A21 is 1, and the word index is A1..A17.
- R5: In large mode, `ram_ce_o` is 1 for every address outside the I/O page. `nxm_o` is 1 exactly when A20 or A21 is 1. The word index is A1..A19, so addresses that differ in A18 or A19 are distinct words.
- R6: A data-phase cycle "hits" when `ram_ce_o`=1 and `nxm_o`=0. On a hit, a read returns the stored word and a write stores `req_wdata` at the word index. Otherwise a read returns 16'hFFFF and a write changes no word.
- R7: When A21..A13 are all 1 (the I/O page), `ram_ce_o`=0, `nxm_o`=0, there is no abort, a read returns 16'hFFFF and a write is dropped. The address just below this page (0x3FDFFE) is decoded as ordinary space.
- R8: `abort_n` is driven 0 only in a data-phase cycle whose `nxm_o` is 1. At every other time it is released to high impedance, and an external pull-up makes it read 1.
- R9: The mode input (0 = 128K words, 1 = 512K words) takes effect only while `rst` is 1. A change while out of reset has no effect until the next reset.
- R10: Address bit A0 is ignored, so an odd address accesses the same word as the even address just below it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_big_i | input | 1 | Memory size select: 0 = 128K words, 1 = 512K words; sampled during reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Byte address |
| req_wdata | input | 16 | Write word |
| rsp_valid | output | 1 | Data phase, one cycle after acceptance |
| rsp_rdata | output | 16 | Read word, or all ones when the cycle does not hit |
| ram_ce_o | output | 1 | RAM chip enable decoded from the captured address |
| nxm_o | output | 1 | Nonexistent-memory flag from the captured address |
| abort_n | output | 1 | Active-low abort; driven low or released to high impedance |

## Verification
Every result of an access belongs to the data-phase cycle that follows the accepting edge: `rsp_valid`, `rsp_rdata`, `ram_ce_o`, `nxm_o` and the level of `abort_n`. A write enters the RAM model at the edge that ends that data phase, so a read accepted one edge later already sees it. The bench drives a request on a falling edge and holds it across the accepting rising edge. It samples all results at the next falling edge, in the middle of the data phase, and never issues a request before `req_ready` has returned. A second instance, built without the upper-bit register, takes the same stimulus, so aliasing and discarded writes can be compared between the two builds on the same cycles.

// File: rtl/memdec_pkg.sv
package memdec_pkg;
  // bus phase of the decoder
  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } phase_e;
endpackage

// File: rtl/memdec_latch.sv
module memdec_latch #(
  parameter int ADDR_W      = 22,
  parameter int LOW_W       = 18,
  parameter bit UPPER_EN    = 1'b1,
  parameter int IOPAGE_LOG2 = 13
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [ADDR_W-1:0]         addr_i,
  output logic [LOW_W-2:0]          word_q,
  output logic [ADDR_W-LOW_W-1:0]   up_q,
  output logic [ADDR_W-LOW_W-1:0]   up_n_q,
  output logic                      iopage_q
);
  localparam int UP_W = ADDR_W - LOW_W;

  // word part of the low address, A0 dropped
  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      iopage_q <= 1'b0;
    end else if (load) begin
      word_q   <= addr_i[LOW_W-1:1];
      iopage_q <= &addr_i[ADDR_W-1:IOPAGE_LOG2];
    end
  end

  generate
    if (UPPER_EN) begin : g_upper
      // edge register with true and inverted outputs
      always_ff @(posedge clk) begin
        if (rst) begin
          up_q   <= '0;
          up_n_q <= '1;
        end else if (load) begin
          up_q   <= addr_i[ADDR_W-1:LOW_W];
          up_n_q <= ~addr_i[ADDR_W-1:LOW_W];
        end
      end
    end else begin : g_no_upper
      logic [UP_W-1:0] unused_up;
      assign unused_up = addr_i[ADDR_W-1:LOW_W];
      assign up_q      = '0;
      assign up_n_q    = '1;
    end
  endgenerate
endmodule

// File: rtl/memdec_decode.sv
module memdec_decode #(
  parameter int LOW_W     = 18,
  parameter int UP_W      = 4,
  parameter int BIG_EXTRA = 2,
  parameter bit UPPER_EN  = 1'b1,
  localparam int IDX_W    = LOW_W - 1 + BIG_EXTRA
) (
  input  logic [LOW_W-2:0] word_i,
  input  logic [UP_W-1:0]  up_i,
  input  logic [UP_W-1:0]  up_n_i,
  input  logic             iopage_i,
  input  logic             big_i,
  output logic             ce_o,
  output logic             nxm_o,
  output logic [IDX_W-1:0] idx_o
);
  logic ce_raw;
  logic nxm_raw;

  generate
    if (UPPER_EN) begin : g_full
      logic [UP_W-1:0] force_hi;
      // large mode: the lowest upper bits are held inactive in the NAND
      assign force_hi = big_i ? {{(UP_W-BIG_EXTRA){1'b0}}, {BIG_EXTRA{1'b1}}} : '0;
      assign nxm_raw  = ~&(up_n_i | force_hi);
      assign ce_raw   = big_i ? 1'b1 : up_n_i[0];
      assign idx_o    = big_i ? {up_i[BIG_EXTRA-1:0], word_i}
                              : {{BIG_EXTRA{1'b0}}, word_i};
    end else begin : g_mirror
      logic unused_dec;
      assign unused_dec = big_i | (|up_i) | (|up_n_i);
      assign nxm_raw    = 1'b0;
      assign ce_raw     = 1'b1;
      assign idx_o      = {{BIG_EXTRA{1'b0}}, word_i};
    end
  endgenerate

  // I/O page overrides both memory-side outputs
  assign ce_o  = ce_raw & ~iopage_i;
  assign nxm_o = nxm_raw & ~iopage_i;
endmodule

// File: rtl/memdec_sram.sv
module memdec_sram #(
  parameter int IDX_W  = 19,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  // sparse behavioural store: only touched words occupy an entry
  logic [DEPTH-1:0]  vld;
  logic [IDX_W-1:0]  key [DEPTH];
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  match;
  logic [PTR_W-1:0]  ptr;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_cmp
      assign match[g] = vld[g] && (key[g] == idx);
    end
  endgenerate

  always_comb begin
    rdata = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match[i]) rdata = mem[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      ptr <= '0;
    end else if (wr_en) begin
      if (|match) begin
        for (int i = 0; i < DEPTH; i++) begin
          if (match[i]) mem[i] <= wdata;
        end
      end else begin
        key[ptr] <= idx;
        mem[ptr] <= wdata;
        vld[ptr] <= 1'b1;
        ptr      <= (ptr == PTR_W'(DEPTH-1)) ? '0 : ptr + 1'b1;
      end
    end
  end

  // R6
  wr_readback_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((idx != $past(idx)) || (rdata == $past(wdata))));
endmodule

// File: rtl/memdec_top.sv
module memdec_top #(
  parameter int ADDR_W      = 22,
  parameter int DATA_W      = 16,
  parameter int LOW_W       = 18,
  parameter int BIG_EXTRA   = 2,
  parameter int IOPAGE_LOG2 = 13,
  parameter int RAM_DEPTH   = 16,
  parameter bit UPPER_EN    = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_big_i,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ram_ce_o,
  output logic              nxm_o,
  output logic              abort_n
);
  import memdec_pkg::*;

  localparam int UP_W  = ADDR_W - LOW_W;
  localparam int IDX_W = LOW_W - 1 + BIG_EXTRA;

  phase_e            phase;
  logic              accept;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              big_q;
  logic [LOW_W-2:0]  word_q;
  logic [UP_W-1:0]   up_q;
  logic [UP_W-1:0]   up_n_q;
  logic              iopage_q;
  logic              ce;
  logic              nxm;
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic              ram_wr;
  logic [DATA_W-1:0] ram_rdata;
  logic              abort_drive;
  logic              unused_a0;

  assign unused_a0 = req_addr[0];
  assign req_ready = (phase == PH_ADDR);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_ADDR;
      we_q    <= 1'b0;
      wdata_q <= '0;
      big_q   <= mode_big_i;
    end else begin
      phase <= accept ? PH_DATA : PH_ADDR;
      if (accept) begin
        we_q    <= req_we;
        wdata_q <= req_wdata;
      end
    end
  end

  memdec_latch #(
    .ADDR_W(ADDR_W), .LOW_W(LOW_W), .UPPER_EN(UPPER_EN), .IOPAGE_LOG2(IOPAGE_LOG2)
  ) u_latch (
    .clk(clk), .rst(rst), .load(accept), .addr_i(req_addr),
    .word_q(word_q), .up_q(up_q), .up_n_q(up_n_q), .iopage_q(iopage_q)
  );

  memdec_decode #(
    .LOW_W(LOW_W), .UP_W(UP_W), .BIG_EXTRA(BIG_EXTRA), .UPPER_EN(UPPER_EN)
  ) u_decode (
    .word_i(word_q), .up_i(up_q), .up_n_i(up_n_q), .iopage_i(iopage_q),
    .big_i(big_q), .ce_o(ce), .nxm_o(nxm), .idx_o(idx)
  );

  assign hit    = ce && !nxm;
  assign ram_wr = (phase == PH_DATA) && we_q && hit;

  memdec_sram #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .DEPTH(RAM_DEPTH)
  ) u_sram (
    .clk(clk), .rst(rst), .wr_en(ram_wr), .idx(idx),
    .wdata(wdata_q), .rdata(ram_rdata)
  );

  assign rsp_valid   = (phase == PH_DATA);
  assign rsp_rdata   = hit ? ram_rdata : '1;
  assign ram_ce_o    = ce;
  assign nxm_o       = nxm;
  assign abort_drive = rsp_valid && nxm;
  assign abort_n     = abort_drive ? 1'b0 : 1'bz;

  // R1
  handshake_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (rsp_valid && !req_ready));

  // R1
  single_beat_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R8
  abort_data_chk: assert property (@(posedge clk) disable iff (rst)
    abort_drive |-> (rsp_rdata == '1));

  // R7
  iopage_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && iopage_q) |-> ((rsp_rdata == '1) && !abort_drive && !ram_wr));

  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(big_q));
endmodule

// File: tb/sim_memdec_top.sv
module sim_memdec_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [21:0] req_addr = '0;
  logic [15:0] req_wdata = '0;

  logic        rdy0, rv0, ce0, nx0, rdy1, rv1, ce1, nx1;
  logic [15:0] rd0, rd1;
  wire         ab0_w, ab1_w;
  pullup (ab0_w);
  pullup (ab1_w);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // sampled data-phase results
  logic [15:0] s_rd0, s_rd1;
  logic        s_v0, s_ce0, s_nx0, s_ab0, s_ce1, s_nx1, s_ab1;

  always #2 clk = ~clk;

  memdec_top u0 (
    .clk(clk), .rst(rst), .mode_big_i(mode), .req_valid(req_valid), .req_ready(rdy0),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv0),
    .rsp_rdata(rd0), .ram_ce_o(ce0), .nxm_o(nx0), .abort_n(ab0_w)
  );

  memdec_top #(.UPPER_EN(1'b0)) u1 (
    .clk(clk), .rst(rst), .mode_big_i(mode), .req_valid(req_valid), .req_ready(rdy1),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv1),
    .rsp_rdata(rd1), .ram_ce_o(ce1), .nxm_o(nx1), .abort_n(ab1_w)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    check(act === exp, req, act, exp);
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    rst  = 1'b1;
    mode = m;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // one bus access: drive at a falling edge, accept at the rising edge,
  // sample the data phase at the next falling edge
  task automatic access(input logic we, input logic [21:0] a, input logic [15:0] d);
    @(negedge clk);
    chk_eq("R1 ready before request", {31'd0, rdy0}, 32'd1);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = a;
    req_wdata = d;
    @(negedge clk);
    s_v0  = rv0;
    s_rd0 = rd0;  s_ce0 = ce0;  s_nx0 = nx0;  s_ab0 = ab0_w;
    s_rd1 = rd1;  s_ce1 = ce1;  s_nx1 = nx1;  s_ab1 = ab1_w;
    chk_eq("R1 rsp_valid in data phase", {31'd0, s_v0}, 32'd1);
    chk_eq("R1 ready low in data phase", {31'd0, rdy0}, 32'd0);
    req_valid = 1'b0;
    req_we    = 1'b0;
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    @(negedge clk);
    chk_eq("R2 ram_ce after reset", {31'd0, ce0}, 32'd1);
    chk_eq("R2 nxm after reset", {31'd0, nx0}, 32'd0);
    chk_eq("R2 abort released after reset", {31'd0, ab0_w}, 32'd1);
    chk_eq("R2 rsp_valid after reset", {31'd0, rv0}, 32'd0);
    chk_eq("R2 ready after reset", {31'd0, rdy0}, 32'd1);
    access(1'b0, 22'h000000, 16'h0);
    chk_eq("R2 empty RAM reads zero", {16'd0, s_rd0}, 32'h0);
    @(negedge clk);
    chk_eq("R1 rsp_valid drops", {31'd0, rv0}, 32'd0);
  endtask

  task automatic t_small;
    access(1'b1, 22'h000010, 16'h1234);
    chk_eq("R4 ce at base", {31'd0, s_ce0}, 32'd1);
    chk_eq("R8 no abort at base", {31'd0, s_ab0}, 32'd1);
    access(1'b0, 22'h000011, 16'h0);
    chk_eq("R10 odd address same word", {16'd0, s_rd0}, 32'h1234);
    access(1'b0, 22'h080010, 16'h0);
    chk_eq("R4 ce with A19", {31'd0, s_ce0}, 32'd1);
    chk_eq("R4 nxm with A19", {31'd0, s_nx0}, 32'd1);
    chk_eq("R8 abort with A19", {31'd0, s_ab0}, 32'd0);
    chk_eq("R6 nxm read all ones", {16'd0, s_rd0}, 32'hFFFF);
    chk_eq("R3 alias read A19", {16'd0, s_rd1}, 32'h1234);
    chk_eq("R3 no nxm without latch", {31'd0, s_nx1}, 32'd0);
    access(1'b1, 22'h300010, 16'h5555);
    chk_eq("R4 nxm with A20 A21", {31'd0, s_nx0}, 32'd1);
    access(1'b0, 22'h000010, 16'h0);
    chk_eq("R6 write dropped at nxm", {16'd0, s_rd0}, 32'h1234);
    chk_eq("R3 alias write seen at base", {16'd0, s_rd1}, 32'h5555);
    access(1'b1, 22'h040010, 16'hAAAA);
    chk_eq("R4 ce low with A18", {31'd0, s_ce0}, 32'd0);
    chk_eq("R4 nxm with A18", {31'd0, s_nx0}, 32'd1);
    chk_eq("R8 abort with A18", {31'd0, s_ab0}, 32'd0);
    chk_eq("R3 ce with A18 without latch", {31'd0, s_ce1}, 32'd1);
    chk_eq("R3 no abort without latch", {31'd0, s_ab1}, 32'd1);
    access(1'b0, 22'h040010, 16'h0);
    chk_eq("R6 A18 read all ones", {16'd0, s_rd0}, 32'hFFFF);
    access(1'b0, 22'h000010, 16'h0);
    chk_eq("R6 A18 write dropped", {16'd0, s_rd0}, 32'h1234);
    chk_eq("R3 A18 alias stored", {16'd0, s_rd1}, 32'hAAAA);
  endtask

  task automatic t_iopage;
    access(1'b1, 22'h3FE010, 16'h7777);
    chk_eq("R7 iopage ce", {31'd0, s_ce0}, 32'd0);
    chk_eq("R7 iopage nxm", {31'd0, s_nx0}, 32'd0);
    chk_eq("R7 iopage no abort", {31'd0, s_ab0}, 32'd1);
    chk_eq("R7 iopage ce no latch", {31'd0, s_ce1}, 32'd0);
    access(1'b0, 22'h3FE010, 16'h0);
    chk_eq("R7 iopage read all ones", {16'd0, s_rd0}, 32'hFFFF);
    access(1'b0, 22'h03E010, 16'h0);
    chk_eq("R7 iopage write dropped", {16'd0, s_rd0}, 32'h0);
    chk_eq("R7 iopage write dropped no latch", {16'd0, s_rd1}, 32'h0);
    access(1'b0, 22'h3FDFFE, 16'h0);
    chk_eq("R7 below iopage is nxm", {31'd0, s_nx0}, 32'd1);
    chk_eq("R8 below iopage aborts", {31'd0, s_ab0}, 32'd0);
  endtask

  task automatic t_mode_hold_small;
    @(negedge clk);
    mode = 1'b1;
    access(1'b0, 22'h040000, 16'h0);
    chk_eq("R9 mode change ignored ce", {31'd0, s_ce0}, 32'd0);
    chk_eq("R9 mode change ignored nxm", {31'd0, s_nx0}, 32'd1);
  endtask

  task automatic t_big;
    do_reset(1'b1);
    access(1'b1, 22'h040020, 16'h0BEE);
    chk_eq("R5 ce with A18", {31'd0, s_ce0}, 32'd1);
    chk_eq("R5 no nxm with A18", {31'd0, s_nx0}, 32'd0);
    chk_eq("R8 no abort large mode", {31'd0, s_ab0}, 32'd1);
    access(1'b0, 22'h040020, 16'h0);
    chk_eq("R5 A18 word readback", {16'd0, s_rd0}, 32'h0BEE);
    access(1'b0, 22'h000020, 16'h0);
    chk_eq("R5 base word distinct", {16'd0, s_rd0}, 32'h0);
    access(1'b1, 22'h0C0020, 16'h0C0C);
    access(1'b0, 22'h0C0020, 16'h0);
    chk_eq("R5 A19 A18 word readback", {16'd0, s_rd0}, 32'h0C0C);
    access(1'b0, 22'h140020, 16'h0);
    chk_eq("R5 ce with A20", {31'd0, s_ce0}, 32'd1);
    chk_eq("R5 nxm with A20", {31'd0, s_nx0}, 32'd1);
    chk_eq("R8 abort with A20", {31'd0, s_ab0}, 32'd0);
    chk_eq("R6 A20 read all ones", {16'd0, s_rd0}, 32'hFFFF);
    access(1'b1, 22'h240020, 16'hDEAD);
    chk_eq("R5 nxm with A21", {31'd0, s_nx0}, 32'd1);
    access(1'b0, 22'h040020, 16'h0);
    chk_eq("R6 A21 write dropped", {16'd0, s_rd0}, 32'h0BEE);
    access(1'b0, 22'h000020, 16'h0);
    chk_eq("R3 mode ignored without latch", {16'd0, s_rd1}, 32'hDEAD);
    access(1'b0, 22'h3FE000, 16'h0);
    chk_eq("R7 iopage large ce", {31'd0, s_ce0}, 32'd0);
    chk_eq("R7 iopage large nxm", {31'd0, s_nx0}, 32'd0);
    @(negedge clk);
    mode = 1'b0;
    access(1'b0, 22'h040020, 16'h0);
    chk_eq("R9 large mode kept", {16'd0, s_rd0}, 32'h0BEE);
    do_reset(1'b0);
    access(1'b0, 22'h040020, 16'h0);
    chk_eq("R9 small after reset ce", {31'd0, s_ce0}, 32'd0);
    chk_eq("R9 small after reset nxm", {31'd0, s_nx0}, 32'd1);
  endtask

  initial begin
    t_reset();
    t_small();
    t_iopage();
    t_mode_hold_small();
    t_big();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule